// File: doc/BRIEF.md
# SMI Status Capture Registers

This block holds two 8-bit status registers that report which event sources want a system-management interrupt. Each status bit has its own rule. Some bits latch an event and hold it until software writes a 1 to them. One bit latches an infrared pin transition and clears when its register is read. Some bits simply mirror an interrupt level that is cleared at its source. The parallel-port bit is held high while the port is inactive and follows the acknowledge input while the port is active.

Software reaches the registers over a plain select/read/write register bus with one address bit. Read data is combinational during a read cycle, and any side effect of the read takes effect at the closing clock edge. Four reset sources exist besides the asynchronous reset `rst_ni`. A standby power-on pulse reloads both registers. The main power-on, bus-reset and soft-reset pulses preset the parallel-port bit. The main power-on pulse can also flag a low battery. A registered `smi_o` output is high whenever any defined status bit is set.

Top module: `smi_status_regs`

## Requirements
- R1: After `rst_ni` is released, register 0 reads 0x02 and register 1 reads 0x00, provided all event inputs are low. `smi_o` is 1.
- R2: Register 0 bit 0 (low battery) is cleared only by a write to address 0 with data bit 0 set. A write with bit 0 clear leaves it unchanged.
- R3: A `stby_por_i` pulse loads register 0 bit 0 with `lowbat_i`, so register 0 reads 0x03 or 0x02 in the next cycle when the sources and the port activate input are low. A `main_por_i` pulse sets bit 0 when `lowbat_i` is high and never clears it.
- R4: Register 0 bit 1 reads 1 one cycle after `pp_act_i` is low. While `pp_act_i` is high it reads the value `pp_ack_i` had one cycle earlier.
- R5: Any of `main_por_i`, `stby_por_i`, `bus_rst_i` or `soft_rst_i` forces register 0 bit 1 to 1 in the next cycle.
- R6: Register 0 bits 2, 3, 4 and 7 show `uart2_irq_i`, `uart1_irq_i`, `fdc_irq_i` and `wdt_evt_i` as they were one cycle earlier. Register 1 bits 0 and 1 show `mouse_irq_i` and `kbd_irq_i` in the same way. Writes do not change these bits.
- R7: Reserved bits read 0. These are register 0 bits 5 and 6, and register 1 bits 3, 5, 6 and 7.
- R8: Any transition on `ir_rx_i` sets register 1 bit 2. The bit becomes visible SYNC_STAGES+1 clock edges after the transition is first sampled.
- R9: A read of address 1 clears register 1 bit 2 at the edge that ends the read. A read of address 0 does not clear it. A `stby_por_i` pulse also clears it.
- R10: Register 1 bit 4 is set by a `wake_click_i` pulse. It is cleared by a write to address 1 with data bit 4 set, or by `stby_por_i`.
- R11: When a set event and a clearing read or write fall in the same cycle, the bit ends up set.
- R12: `smi_o` is the OR of all defined status bits of both registers, delayed by one cycle.
- R13: `bus_rdata_o` shows register 0 when `bus_addr_i` is 0 and register 1 when it is 1, but only while `bus_sel_i` and `bus_rd_i` are both high. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_por_i | input | 1 | Main power-on reset pulse |
| stby_por_i | input | 1 | Standby power-on reset pulse |
| bus_rst_i | input | 1 | Bus reset pulse |
| soft_rst_i | input | 1 | Soft reset pulse |
| lowbat_i | input | 1 | Low-battery indication from the comparator |
| pp_act_i | input | 1 | Parallel port activate control |
| pp_ack_i | input | 1 | Parallel port acknowledge input |
| uart1_irq_i | input | 1 | First UART interrupt level |
| uart2_irq_i | input | 1 | Second UART interrupt level |
| fdc_irq_i | input | 1 | Floppy controller interrupt level |
| wdt_evt_i | input | 1 | Watchdog event level |
| mouse_irq_i | input | 1 | Mouse interrupt level |
| kbd_irq_i | input | 1 | Keyboard interrupt level |
| ir_rx_i | input | 1 | Asynchronous infrared receive pin |
| wake_click_i | input | 1 | Mouse-click wake event pulse |
| bus_sel_i | input | 1 | Register bus select |
| bus_addr_i | input | 1 | Register address (0 or 1) |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| smi_o | output | 1 | Registered combined SMI request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This shows that the infrared set latency follows the parameter and is not fixed at a hard-wired depth. It also brings into reach collisions between a late edge and a read that a shorter chain would not line up in the same cycle. Random rare reset pulses, write-one patterns and read timing then push every set-versus-clear collision on all three latched bits.

// File: rtl/smi_pkg.sv
`timescale 1ns/1ps
package smi_pkg;
  localparam int REG_W = 8;

  // register 0 bit positions
  localparam int S0_LOWBAT = 0;
  localparam int S0_PPORT  = 1;
  localparam int S0_UART2  = 2;
  localparam int S0_UART1  = 3;
  localparam int S0_FLOPPY = 4;
  localparam int S0_WDOG   = 7;

  // register 1 bit positions
  localparam int S1_MOUSE = 0;
  localparam int S1_KBD   = 1;
  localparam int S1_IRRX  = 2;
  localparam int S1_WAKE  = 4;

  localparam logic [REG_W-1:0] S0_LIVE = 8'h9F;
  localparam logic [REG_W-1:0] S1_LIVE = 8'h17;

  typedef enum logic { SEL_STAT0 = 1'b0, SEL_STAT1 = 1'b1 } smi_sel_e;

  typedef struct packed {
    logic main_por;
    logic stby_por;
    logic bus_rst;
    logic soft_rst;
  } smi_rst_s;
endpackage

// File: rtl/smi_edge_sync.sv
`timescale 1ns/1ps
module smi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic edge_o
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign edge_o = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];

  initial begin
    assert_depth_ok_R8: assert (STAGES >= 2)
      else $error("synchronizer needs two stages or more");
  end
endmodule

// File: rtl/smi_stat0.sv
`timescale 1ns/1ps
module smi_stat0
  import smi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  smi_rst_s         rst_evt_i,
  input  logic             lowbat_i,
  input  logic             pp_act_i,
  input  logic             pp_ack_i,
  input  logic             uart1_i,
  input  logic             uart2_i,
  input  logic             floppy_i,
  input  logic             wdog_i,
  input  logic             clr_lowbat_i,
  output logic [REG_W-1:0] stat_o
);
  logic       lowbat_q;
  logic       pport_q;
  logic [3:0] src_q;
  logic       any_rst;
  logic       lowbat_set;

  assign any_rst    = |rst_evt_i;
  assign lowbat_set = rst_evt_i.main_por & lowbat_i;

  // low battery: standby POR loads, main POR sets, write-one clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 lowbat_q <= 1'b0;
    else if (rst_evt_i.stby_por) lowbat_q <= lowbat_i;
    else if (lowbat_set)         lowbat_q <= 1'b1;
    else if (clr_lowbat_i)       lowbat_q <= 1'b0;
  end

  // parallel port: preset by resets or inactive port, else follow ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pport_q <= 1'b1;
    else if (!pp_act_i || any_rst) pport_q <= 1'b1;
    else                           pport_q <= pp_ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= {wdog_i, floppy_i, uart1_i, uart2_i};
  end

  always_comb begin
    stat_o            = '0;
    stat_o[S0_LOWBAT] = lowbat_q;
    stat_o[S0_PPORT]  = pport_q;
    stat_o[S0_UART2]  = src_q[0];
    stat_o[S0_UART1]  = src_q[1];
    stat_o[S0_FLOPPY] = src_q[2];
    stat_o[S0_WDOG]   = src_q[3];
  end

  assert_lowbat_w1c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_lowbat_i && !rst_evt_i.stby_por && !lowbat_set) |=> !lowbat_q);
  assert_lowbat_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lowbat_q && !clr_lowbat_i && !rst_evt_i.stby_por) |=> lowbat_q);
  assert_stby_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_evt_i.stby_por |=> (lowbat_q == $past(lowbat_i)));
  assert_lowbat_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowbat_set |=> lowbat_q);
  assert_pport_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pp_act_i |=> pport_q);
  assert_pport_preset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rst |=> pport_q);
endmodule

// File: rtl/smi_stat1.sv
`timescale 1ns/1ps
module smi_stat1
  import smi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stby_por_i,
  input  logic             mouse_i,
  input  logic             kbd_i,
  input  logic             ir_edge_i,
  input  logic             rd_clr_i,
  input  logic             wake_evt_i,
  input  logic             clr_wake_i,
  output logic [REG_W-1:0] stat_o
);
  logic       ir_q;
  logic       wake_q;
  logic [1:0] lvl_q;

  // set outranks clear so that no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ir_q <= 1'b0;
    else if (stby_por_i) ir_q <= 1'b0;
    else if (ir_edge_i)  ir_q <= 1'b1;
    else if (rd_clr_i)   ir_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wake_q <= 1'b0;
    else if (stby_por_i) wake_q <= 1'b0;
    else if (wake_evt_i) wake_q <= 1'b1;
    else if (clr_wake_i) wake_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= {kbd_i, mouse_i};
  end

  always_comb begin
    stat_o           = '0;
    stat_o[S1_MOUSE] = lvl_q[0];
    stat_o[S1_KBD]   = lvl_q[1];
    stat_o[S1_IRRX]  = ir_q;
    stat_o[S1_WAKE]  = wake_q;
  end

  assert_ir_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_edge_i && !stby_por_i) |=> ir_q);
  assert_ir_rdclr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !ir_edge_i) |=> !ir_q);
  assert_ir_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_q && !rd_clr_i && !stby_por_i) |=> ir_q);
  assert_wake_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wake_i && !wake_evt_i) |=> !wake_q);
  assert_wake_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_evt_i && !stby_por_i) |=> wake_q);
endmodule

// File: rtl/smi_status_regs.sv
`timescale 1ns/1ps
module smi_status_regs
  import smi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             main_por_i,
  input  logic             stby_por_i,
  input  logic             bus_rst_i,
  input  logic             soft_rst_i,
  input  logic             lowbat_i,
  input  logic             pp_act_i,
  input  logic             pp_ack_i,
  input  logic             uart1_irq_i,
  input  logic             uart2_irq_i,
  input  logic             fdc_irq_i,
  input  logic             wdt_evt_i,
  input  logic             mouse_irq_i,
  input  logic             kbd_irq_i,
  input  logic             ir_rx_i,
  input  logic             wake_click_i,
  input  logic             bus_sel_i,
  input  logic             bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [7:0]       bus_wdata_i,
  output logic [7:0]       bus_rdata_o,
  output logic             smi_o
);
  smi_rst_s         rst_evt;
  smi_sel_e         sel;
  logic             rd_cyc, wr_cyc;
  logic             clr_lowbat, clr_wake, rd_clr_ir;
  logic             ir_edge;
  logic [REG_W-1:0] stat0, stat1;
  logic             smi_q;

  assign rst_evt = '{main_por: main_por_i, stby_por: stby_por_i,
                     bus_rst: bus_rst_i, soft_rst: soft_rst_i};
  assign sel     = smi_sel_e'(bus_addr_i);
  assign rd_cyc  = bus_sel_i & bus_rd_i;
  assign wr_cyc  = bus_sel_i & bus_wr_i;

  assign clr_lowbat = wr_cyc & (sel == SEL_STAT0) & bus_wdata_i[S0_LOWBAT];
  assign clr_wake   = wr_cyc & (sel == SEL_STAT1) & bus_wdata_i[S1_WAKE];
  assign rd_clr_ir  = rd_cyc & (sel == SEL_STAT1);

  smi_edge_sync #(.STAGES(SYNC_STAGES)) u_ir_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ir_rx_i),
    .edge_o (ir_edge)
  );

  smi_stat0 u_stat0 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rst_evt_i    (rst_evt),
    .lowbat_i     (lowbat_i),
    .pp_act_i     (pp_act_i),
    .pp_ack_i     (pp_ack_i),
    .uart1_i      (uart1_irq_i),
    .uart2_i      (uart2_irq_i),
    .floppy_i     (fdc_irq_i),
    .wdog_i       (wdt_evt_i),
    .clr_lowbat_i (clr_lowbat),
    .stat_o       (stat0)
  );

  smi_stat1 u_stat1 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stby_por_i (stby_por_i),
    .mouse_i    (mouse_irq_i),
    .kbd_i      (kbd_irq_i),
    .ir_edge_i  (ir_edge),
    .rd_clr_i   (rd_clr_ir),
    .wake_evt_i (wake_click_i),
    .clr_wake_i (clr_wake),
    .stat_o     (stat1)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd_cyc) bus_rdata_o = (sel == SEL_STAT1) ? stat1 : stat0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b1;
    else         smi_q <= |{stat0 & S0_LIVE, stat1 & S1_LIVE};
  end
  assign smi_o = smi_q;

  always_comb begin
    if (rst_ni) begin
      assert_reserved_zero_R7: assert ((stat0 & ~S0_LIVE) == '0 && (stat1 & ~S1_LIVE) == '0)
        else $error("reserved status bit set");
    end
  end

  assert_smi_rise_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{stat0, stat1}) |=> smi_o);
  assert_smi_fall_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|{stat0, stat1}) |=> !smi_o);
  assert_read_stable_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_cyc) |-> (bus_rdata_o == '0));
endmodule

// File: tb/smi_status_regs_bench.sv
`timescale 1ns/1ps
module smi_status_regs_bench;
  localparam int SYNC = 3;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic main_por_i, stby_por_i, bus_rst_i, soft_rst_i, lowbat_i;
  logic pp_act_i, pp_ack_i, uart1_irq_i, uart2_irq_i, fdc_irq_i, wdt_evt_i;
  logic mouse_irq_i, kbd_irq_i, ir_rx_i, wake_click_i;
  logic bus_sel_i, bus_addr_i, bus_wr_i, bus_rd_i;
  logic [7:0] bus_wdata_i, bus_rdata_o;
  logic smi_o;

  always #2 clk_i = ~clk_i;

  smi_status_regs #(.SYNC_STAGES(SYNC)) u_smi_status_regs (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  string tag;

  // model state
  logic m_low, m_pint, m_ms, m_kb, m_ir, m_wake, m_smi;
  logic [3:0] m_src; // {wdt, fdc, uart1, uart2}
  logic [SYNC:0] m_chain;

  function automatic logic [7:0] exp_r0();
    return {m_src[3], 2'b00, m_src[2], m_src[1], m_src[0], m_pint, m_low};
  endfunction
  function automatic logic [7:0] exp_r1();
    return {3'b000, m_wake, 1'b0, m_ir, m_kb, m_ms};
  endfunction
  function automatic logic [7:0] exp_rd();
    if (!(bus_sel_i && bus_rd_i)) return 8'h00;
    return bus_addr_i ? exp_r1() : exp_r0();
  endfunction

  task automatic model_reset();
    m_low = 0; m_pint = 1; m_ms = 0; m_kb = 0; m_ir = 0; m_wake = 0;
    m_smi = 1; m_src = '0; m_chain = '0;
  endtask

  task automatic model_step();
    logic anyr, edg, rd1, wr0, wr1, smi_n;
    anyr  = main_por_i | stby_por_i | bus_rst_i | soft_rst_i;
    edg   = m_chain[SYNC] ^ m_chain[SYNC-1];
    rd1   = bus_sel_i & bus_rd_i & bus_addr_i;
    wr0   = bus_sel_i & bus_wr_i & !bus_addr_i & bus_wdata_i[0];
    wr1   = bus_sel_i & bus_wr_i & bus_addr_i & bus_wdata_i[4];
    smi_n = |{exp_r0(), exp_r1()};
    if (stby_por_i) m_low = lowbat_i;
    else if (main_por_i && lowbat_i) m_low = 1;
    else if (wr0) m_low = 0;
    m_pint = (!pp_act_i || anyr) ? 1'b1 : pp_ack_i;
    m_src  = {wdt_evt_i, fdc_irq_i, uart1_irq_i, uart2_irq_i};
    m_ms = mouse_irq_i; m_kb = kbd_irq_i;
    if (stby_por_i) m_ir = 0; else if (edg) m_ir = 1; else if (rd1) m_ir = 0;
    if (stby_por_i) m_wake = 0; else if (wake_click_i) m_wake = 1; else if (wr1) m_wake = 0;
    m_chain = {m_chain[SYNC-1:0], ir_rx_i};
    m_smi = smi_n;
  endtask

  task automatic check(string t, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", t, act, exp);
    end
  endtask

  // called just after a negedge with inputs set; ends at the next negedge
  task automatic cyc();
    #1;
    check({tag, " rdata"}, bus_rdata_o, exp_rd());
    check("R12 smi_o", {7'd0, smi_o}, {7'd0, m_smi});
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic idle();
    {main_por_i, stby_por_i, bus_rst_i, soft_rst_i, lowbat_i} = '0;
    {uart1_irq_i, uart2_irq_i, fdc_irq_i, wdt_evt_i, mouse_irq_i, kbd_irq_i} = '0;
    {wake_click_i, bus_sel_i, bus_addr_i, bus_wr_i, bus_rd_i} = '0;
    bus_wdata_i = '0;
  endtask

  task automatic rd(logic a);
    bus_sel_i = 1; bus_rd_i = 1; bus_wr_i = 0; bus_addr_i = a; cyc();
    bus_sel_i = 0; bus_rd_i = 0;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    bus_sel_i = 1; bus_wr_i = 1; bus_rd_i = 0; bus_addr_i = a; bus_wdata_i = d; cyc();
    bus_sel_i = 0; bus_wr_i = 0; bus_wdata_i = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0311));
    idle(); pp_act_i = 0; pp_ack_i = 0; ir_rx_i = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1; model_reset();

    // R1 reset values
    tag = "R1"; rd(0); check("R1 reg0", exp_r0(), 8'h02); rd(1); check("R1 reg1", exp_r1(), 8'h00);

    // R3 standby preload with low battery, main POR set
    tag = "R3"; lowbat_i = 1; stby_por_i = 1; cyc(); stby_por_i = 0; lowbat_i = 0;
    rd(0); check("R3 reg0 preload", exp_r0(), 8'h03);
    // R2 writing zero has no effect, writing one clears
    tag = "R2"; wr(0, 8'h00); rd(0); wr(0, 8'hFE); rd(0); wr(0, 8'h01); rd(0);
    tag = "R3"; lowbat_i = 1; main_por_i = 1; cyc(); main_por_i = 0; lowbat_i = 0; rd(0);
    // R11 set against clear in one cycle
    tag = "R11"; lowbat_i = 1; main_por_i = 1; wr(0, 8'h01); main_por_i = 0; lowbat_i = 0; rd(0);
    wake_click_i = 1; wr(1, 8'h10); wake_click_i = 0; rd(1);
    // R10 wake W1C
    tag = "R10"; wr(1, 8'h10); rd(1);

    // R4 parallel port follow, R5 preset
    tag = "R4"; pp_ack_i = 0; cyc(); rd(0); pp_act_i = 1; cyc(); rd(0); pp_ack_i = 1; cyc(); rd(0);
    pp_ack_i = 0; cyc(); rd(0);
    tag = "R5"; soft_rst_i = 1; cyc(); soft_rst_i = 0; bus_sel_i = 1; bus_rd_i = 1; cyc(); idle();
    bus_rst_i = 1; cyc(); bus_rst_i = 0; rd(0);

    // R6 read-only mirrors, writes ignored
    tag = "R6"; {uart1_irq_i, fdc_irq_i, mouse_irq_i} = 3'b111; cyc(); rd(0); rd(1);
    wr(0, 8'h00); wr(1, 8'h00); rd(0); rd(1); idle(); cyc();
    // R7 reserved bits
    tag = "R7"; wr(0, 8'hFF); wr(1, 8'hFF); rd(0); check("R7 reg0 reserved", exp_r0() & 8'h60, 8'h00);
    rd(1);

    // R8 IR edge latency, R9 read clears, reg0 read leaves it
    tag = "R8"; ir_rx_i = 1; for (int i = 0; i < SYNC + 2; i++) begin bus_sel_i = 1; bus_rd_i = 1; bus_addr_i = 0; cyc(); end
    idle();
    tag = "R9"; rd(0); rd(1); rd(1);
    // R11 edge and read meet in one cycle
    tag = "R11"; ir_rx_i = 0; for (int i = 0; i < SYNC + 3; i++) rd(1);

    // R13 and mixed random traffic
    tag = "R13 random";
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom();
      main_por_i = (r[4:0] == 0); bus_rst_i = (r[9:5] == 1); soft_rst_i = (r[14:10] == 2);
      stby_por_i = ($urandom_range(0, 63) == 0); lowbat_i = r[15];
      pp_act_i = (r[17:16] != 0); pp_ack_i = r[18];
      {uart1_irq_i, uart2_irq_i, fdc_irq_i, wdt_evt_i, mouse_irq_i, kbd_irq_i} = 6'($urandom()) & 6'($urandom());
      if ($urandom_range(0, 5) == 0) ir_rx_i = ~ir_rx_i;
      wake_click_i = ($urandom_range(0, 15) == 0);
      bus_sel_i = r[19]; bus_addr_i = r[20]; bus_rd_i = r[21]; bus_wr_i = r[22] & ~r[21];
      bus_wdata_i = r[31:24];
      cyc();
    end
    idle(); pp_act_i = 0; cyc(); cyc();
    tag = "R12"; rd(0); rd(1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule